// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block gathers 32 interrupt request lines and turns them into two processor-facing requests: a normal interrupt and a fast interrupt. Each line has its own enable, its own active sense (high/rising or low/falling) and its own trigger mode (level or edge). Edge events are held in a per-line latch until software acknowledges them by writing a one to that bit. Every input first passes through a two-flop synchroniser.

Software reaches the block over a small synchronous bus with byte offsets that step by one word. A status read returns every pending, enabled source at once, so a handler can service several sources per read. A routing word picks, per source, whether the source drives the normal or the fast request. The outputs can feed a processor directly or feed one input of a parent controller.

Top module: `irqc_top`

## Requirements
- R1: Offsets are 0x00 enable, 0x04 raw status, 0x08 masked status, 0x0C sense, 0x10 trigger mode, 0x14 route. Read data appears on `busRdata` at the clock edge after a read request. Any other offset reads as zero. Writes to 0x08 or to an unmapped offset change no register.
- R2: An enable bit of 1 lets its source reach the outputs. Clearing the bit blocks the source and leaves its raw status unchanged.
- R3: A sense bit of 1 selects active-high or rising edge. A sense bit of 0 selects active-low or falling edge.
- R4: With a mode bit of 0 (level), the raw bit follows the sense-adjusted synchronised input every cycle. Writing 1 to that raw bit has no lasting effect.
- R5: With a mode bit of 1 (edge), the selected edge of the synchronised input sets the raw bit. The bit stays set after the input returns until software writes 1 to it at offset 0x04. Writing 0 there has no effect.
- R6: If a new edge and a clearing write to the same bit land in the same cycle, the bit stays set.
- R7: The masked status word equals the raw status word ANDed with the enable word.
- R8: `irqOut` is the OR of the masked bits whose route bit is 0. `fiqOut` is the OR of the masked bits whose route bit is 1.
- R9: Reset clears the enable, sense, mode and route words and all edge latches, so both outputs are low after reset.
- R10: Changing the sense of an edge source latches nothing unless the input line itself moves. An edge latch is held clear while its source is in level mode, so a source switched to edge mode starts with no pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Asynchronous interrupt request lines |
| busSel | input | 1 | Bus access request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Level-mode routing is tried with six configurations of enable, sense, route and input. These separate the all-disabled case, single-bit and half-word enables, active-low sensing, sources split between both outputs, and inputs that are all inactive. Edge mode is driven with rising and falling pulses. These show that a latch outlives its pulse, that zero writes are ignored, and that one writes acknowledge. A clearing write is placed in the same cycle as a fresh edge, which tells set-priority apart from clear-priority. Sense and mode changes with a steady input show whether a reconfiguration creates false events.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int OFF_ENABLE = 'h00;
  localparam int OFF_RAW    = 'h04;
  localparam int OFF_STATUS = 'h08;
  localparam int OFF_SENSE  = 'h0C;
  localparam int OFF_MODE   = 'h10;
  localparam int OFF_ROUTE  = 'h14;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_RAW,
    SEL_STATUS,
    SEL_SENSE,
    SEL_MODE,
    SEL_ROUTE,
    SEL_NONE
  } regSel_e;

  // strobes from bus decode to the datapath
  typedef struct packed {
    logic    wrEnable;
    logic    wrSense;
    logic    wrMode;
    logic    wrRoute;
    logic    wrAck;
    logic    rdEn;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  regSel_e hitSel;

  always_comb begin
    if (busAddr == ADDR_W'(OFF_ENABLE))      hitSel = SEL_ENABLE;
    else if (busAddr == ADDR_W'(OFF_RAW))    hitSel = SEL_RAW;
    else if (busAddr == ADDR_W'(OFF_STATUS)) hitSel = SEL_STATUS;
    else if (busAddr == ADDR_W'(OFF_SENSE))  hitSel = SEL_SENSE;
    else if (busAddr == ADDR_W'(OFF_MODE))   hitSel = SEL_MODE;
    else if (busAddr == ADDR_W'(OFF_ROUTE))  hitSel = SEL_ROUTE;
    else                                     hitSel = SEL_NONE;
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = hitSel;
    strobe.rdEn     = busSel && !busWe;
    if (busSel && busWe) begin
      strobe.wrEnable = (hitSel == SEL_ENABLE);
      strobe.wrAck    = (hitSel == SEL_RAW);
      strobe.wrSense  = (hitSel == SEL_SENSE);
      strobe.wrMode   = (hitSel == SEL_MODE);
      strobe.wrRoute  = (hitSel == SEL_ROUTE);
    end
  end

endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  busStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic [NUM_SRC-1:0] rawVec,
  output logic [NUM_SRC-1:0] enableQ,
  output logic               irqOut,
  output logic               fiqOut
);

  logic [NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] senseQ;
  logic [NUM_SRC-1:0] modeQ;
  logic [NUM_SRC-1:0] routeQ;
  logic [NUM_SRC-1:0] latchQ;
  logic [NUM_SRC-1:0] levelAdj;
  logic [NUM_SRC-1:0] edgeHit;
  logic [NUM_SRC-1:0] ackVec;
  logic [NUM_SRC-1:0] maskedVec;

  irqc_sync #(
    .WIDTH (NUM_SRC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(srcIn),
    .syncOut(syncQ)
  );

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      senseQ  <= '0;
      modeQ   <= '0;
      routeQ  <= '0;
    end else begin
      if (strobe.wrEnable) enableQ <= busWdata;
      if (strobe.wrSense)  senseQ  <= busWdata;
      if (strobe.wrMode)   modeQ   <= busWdata;
      if (strobe.wrRoute)  routeQ  <= busWdata;
    end
  end

  // edge detection compares raw line samples, so a sense change alone is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  assign levelAdj = ~(syncQ ^ senseQ);
  assign edgeHit  = modeQ & ((senseQ & syncQ & ~prevQ) | (~senseQ & ~syncQ & prevQ));
  assign ackVec   = strobe.wrAck ? busWdata : '0;

  // set beats clear; latch held empty while the source is in level mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= modeQ & ((latchQ & ~ackVec) | edgeHit);
  end

  assign rawVec    = (modeQ & latchQ) | (~modeQ & levelAdj);
  assign maskedVec = rawVec & enableQ;
  assign irqOut    = |(maskedVec & ~routeQ);
  assign fiqOut    = |(maskedVec & routeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdEn) begin
      case (strobe.rdSel)
        SEL_ENABLE: busRdata <= enableQ;
        SEL_RAW:    busRdata <= rawVec;
        SEL_STATUS: busRdata <= maskedVec;
        SEL_SENSE:  busRdata <= senseQ;
        SEL_MODE:   busRdata <= modeQ;
        SEL_ROUTE:  busRdata <= routeQ;
        default:    busRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  busStrobe_t         strobe;
  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] enableQ;

  irqc_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  irqc_datapath #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .rawVec  (rawVec),
    .enableQ (enableQ),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [NUM_SRC-1:0] busWdata,
  input logic [NUM_SRC-1:0] busRdata,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] rawVec,
  input logic [NUM_SRC-1:0] enableQ
);

  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_ROUTE   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_UNMAP   = ADDR_W'('h18);

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |=> (!irqOut && !fiqOut));

  p_enable_off_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == A_ENABLE && busWdata == '0) |=> (!irqOut && !fiqOut));

  p_all_fast_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == A_ROUTE && busWdata == '1) |=> !irqOut);

  p_all_normal_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == A_ROUTE && busWdata == '0) |=> !fiqOut);

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr >= A_UNMAP) |=> (busRdata == '0));

  p_masked_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == A_STATUS) |=> (busRdata == $past(rawVec & enableQ)));

endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) u_irqc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .rawVec  (rawVec),
  .enableQ (enableQ)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [4:0] A_ENABLE = 5'h00;
  localparam logic [4:0] A_RAW    = 5'h04;
  localparam logic [4:0] A_STATUS = 5'h08;
  localparam logic [4:0] A_SENSE  = 5'h0C;
  localparam logic [4:0] A_MODE   = 5'h10;
  localparam logic [4:0] A_ROUTE  = 5'h14;

  typedef struct packed {
    logic [31:0] enable;
    logic [31:0] sense;
    logic [31:0] route;
    logic [31:0] src;
    logic [31:0] expMasked;
    logic        expIrq;
    logic        expFiq;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0},
    '{32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_00F0, 32'h0000_FF0F, 1'b1, 1'b0},
    '{32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_0000, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1},
    '{32'h0000_0003, 32'h0000_0003, 32'h0000_0001, 32'h0000_0003, 32'h0000_0003, 1'b1, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = 32'hFFFF_FFFF;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  irqc_top i_irqc_top (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] addr, input logic [31:0] data);
    busSel = 1'b1; busWe = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] addr, output logic [31:0] data);
    busSel = 1'b1; busWe = 1'b0; busAddr = addr;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0;
    data = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R9: reset state
    busRead(A_ENABLE, rd); check("R9 enable reset", rd, 32'h0);
    busRead(A_SENSE, rd);  check("R9 sense reset", rd, 32'h0);
    busRead(A_MODE, rd);   check("R9 mode reset", rd, 32'h0);
    busRead(A_ROUTE, rd);  check("R9 route reset", rd, 32'h0);
    busRead(A_RAW, rd);    check("R9 raw reset", rd, 32'h0);
    check("R9 outputs low", {30'h0, irqOut, fiqOut}, 32'h0);

    // R1: register map readback, ignored writes, unmapped reads
    busWrite(A_ENABLE, 32'h8000_0001);
    busWrite(A_SENSE, 32'hA5A5_5A5A);
    busWrite(A_ROUTE, 32'h0F0F_F0F0);
    busRead(A_ENABLE, rd); check("R1 enable readback", rd, 32'h8000_0001);
    busRead(A_SENSE, rd);  check("R1 sense readback", rd, 32'hA5A5_5A5A);
    busRead(A_ROUTE, rd);  check("R1 route readback", rd, 32'h0F0F_F0F0);
    busWrite(A_STATUS, 32'hFFFF_FFFF);
    busWrite(5'h18, 32'hFFFF_FFFF);
    busRead(A_ENABLE, rd); check("R1 status write ignored", rd, 32'h8000_0001);
    busRead(A_SENSE, rd);  check("R1 unmapped write ignored", rd, 32'hA5A5_5A5A);
    busRead(5'h18, rd);    check("R1 unmapped read zero", rd, 32'h0);
    busRead(5'h1C, rd);    check("R1 unmapped read zero 1C", rd, 32'h0);
    busWrite(A_ENABLE, 32'h0);
    busWrite(A_SENSE, 32'h0);
    busWrite(A_ROUTE, 32'h0);

    // R3 R7 R8: level-mode table
    for (int i = 0; i < NVEC; i++) begin
      busWrite(A_MODE, 32'h0);
      busWrite(A_ENABLE, VECS[i].enable);
      busWrite(A_SENSE, VECS[i].sense);
      busWrite(A_ROUTE, VECS[i].route);
      srcIn = VECS[i].src;
      settle();
      busRead(A_STATUS, rd);
      check("R7 R3 masked status", rd, VECS[i].expMasked);
      check("R8 irqOut", {31'h0, irqOut}, {31'h0, VECS[i].expIrq});
      check("R8 fiqOut", {31'h0, fiqOut}, {31'h0, VECS[i].expFiq});
    end

    // R5: rising edge on source 4
    srcIn = 32'h0;
    busWrite(A_ROUTE, 32'h0);
    busWrite(A_ENABLE, 32'h10);
    busWrite(A_SENSE, 32'h10);
    busWrite(A_MODE, 32'h10);
    settle();
    busRead(A_STATUS, rd); check("R5 no edge yet", rd, 32'h0);
    srcIn = 32'h10; settle();
    busRead(A_STATUS, rd); check("R5 rising edge latched", rd, 32'h10);
    check("R5 irq on edge", {31'h0, irqOut}, 32'h1);
    srcIn = 32'h0; settle();
    busRead(A_STATUS, rd); check("R5 latch outlives pulse", rd, 32'h10);
    busWrite(A_RAW, 32'h0);
    busRead(A_STATUS, rd); check("R5 zero write no effect", rd, 32'h10);
    busWrite(A_RAW, 32'h10);
    busRead(A_STATUS, rd); check("R5 one write clears", rd, 32'h0);
    check("R5 irq drops", {31'h0, irqOut}, 32'h0);

    // R6: edge and clear in the same cycle
    srcIn = 32'h10; settle();
    srcIn = 32'h0; settle();
    srcIn = 32'h10;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    busWrite(A_RAW, 32'h10);
    busRead(A_STATUS, rd); check("R6 set wins over clear", rd, 32'h10);

    // R10: sense change with steady input latches nothing
    settle();
    busWrite(A_RAW, 32'h10);
    busWrite(A_SENSE, 32'h0);
    settle();
    busRead(A_STATUS, rd); check("R10 sense change no edge", rd, 32'h0);

    // R3: falling edge
    srcIn = 32'h0; settle();
    busRead(A_STATUS, rd); check("R3 falling edge latched", rd, 32'h10);

    // R2: disable keeps raw state
    busWrite(A_ENABLE, 32'h0);
    check("R2 disabled no irq", {31'h0, irqOut}, 32'h0);
    busRead(A_RAW, rd); check("R2 raw kept", rd & 32'h10, 32'h10);
    busWrite(A_ENABLE, 32'h10);
    check("R2 re-enable irq", {31'h0, irqOut}, 32'h1);

    // R8: route to fast output
    busWrite(A_ROUTE, 32'h10);
    check("R8 routed fiq", {30'h0, irqOut, fiqOut}, 32'h1);
    busWrite(A_ROUTE, 32'h0);

    // R4: level mode ignores clearing writes
    busWrite(A_MODE, 32'h0);
    busRead(A_RAW, rd); check("R4 level raw follows", rd & 32'h10, 32'h10);
    busWrite(A_RAW, 32'h10);
    @(negedge clk);
    busRead(A_RAW, rd); check("R4 clear has no lasting effect", rd & 32'h10, 32'h10);

    // R10: back to edge mode starts empty
    busWrite(A_MODE, 32'h10);
    settle();
    busRead(A_STATUS, rd); check("R10 mode switch empty", rd, 32'h0);

    finishRun();
  end

endmodule